// File: doc/BRIEF.md
# Receive-side hardware flow control

This block drives the active-low request-to-send line that tells a remote transmitter whether it may keep sending, based on how full the local receive FIFO is. It also raises a receive trigger flag once the FIFO holds at least the programmed number of characters. Both outputs are registered and change one clock after the inputs.

The receive trigger level comes from one of four fixed tables, chosen by a table select, and one of four entries within that table, chosen by a level select. With tables A, B and C the line does not switch at the trigger level itself. It goes high (stop) when the count reaches the table entry one step above the trigger. It returns low (go) when the count falls to the table entry one step below the trigger. Between those two points it keeps its state. Table D has no hysteresis. When automatic flow control is off, the line follows a software request bit.

Top module: `rx_flow_ctl`

## Requirements
- R1: While reset is active and on the first cycle after it, `rts_n` is 0 (the remote may send) and `rx_trig` is 0.
- R2: With `auto_en` = 0, one cycle after the inputs are presented `rts_n` equals the inverse of `sw_rts`, whatever `rx_count` is.
- R3: With `auto_en` = 1 and `tbl_sel` 0, 1 or 2 (tables A, B, C), `rts_n` is 1 one cycle after `rx_count` is at or above the entry one step above the selected level.
- R4: With `auto_en` = 1 and tables A, B or C, `rts_n` is 0 one cycle after `rx_count` is at or below the entry one step below the selected level.
- R5: With `auto_en` = 1 and `rx_count` strictly between the two thresholds, `rts_n` keeps its previous value.
- R6: When `lvl_sel` = 3 (the top entry) in tables A, B or C, the upper threshold is that entry itself.
- R7: When `lvl_sel` = 0 (the bottom entry) in tables A, B or C, the lower threshold is 0, so `rts_n` returns to 0 only when the FIFO is empty.
- R8: With `tbl_sel` = 3 (table D), `rts_n` is 1 when `rx_count` is at or above the selected level and 0 when it is below, with no hysteresis.
- R9: One cycle after the inputs, `rx_trig` is 1 exactly when `rx_count` is at or above the selected level, whether or not `auto_en` is set.
- R10: Level table, indexed by `lvl_sel` 0..3: A = 1, 4, 8, 14; B = 8, 16, 24, 28; C = 8, 16, 56, 60; D = 16, 64, 128, 224. `rx_count` is 9 bits wide so that it covers 0 to 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_count | input | 9 | Number of characters in the receive FIFO |
| tbl_sel | input | 2 | Trigger table select: 0=A, 1=B, 2=C, 3=D |
| lvl_sel | input | 2 | Entry within the selected table |
| auto_en | input | 1 | Enables automatic flow control |
| sw_rts | input | 1 | Software request: 1 drives `rts_n` low when automatic control is off |
| rts_n | output | 1 | Flow-control output, active low |
| rx_trig | output | 1 | Receive FIFO has reached the selected trigger level |

## Verification
The bench walks the count through each threshold and one below it. A design that compared against the trigger level instead of the next entry would stop the sender at 56 instead of 60 with table C. The band between the thresholds is entered from both sides to catch an output that was decoded from the count instead of held. The top and bottom entries are tested separately: an index that wrapped instead of saturating would produce an upper threshold of 8 or a lower threshold of 60. Table D and software mode are checked as well, because a design that let the count leak into manual mode, or kept the hysteresis on table D, would still look correct on tables A to C.

// File: rtl/rx_fc_pkg.sv
// rx_fc_pkg: shared types, widths and trigger tables for receive flow control.
// Assumes a 256-entry FIFO, so the count needs 9 bits to reach 256.
package rx_fc_pkg;
    localparam int FIFO_DEPTH = 256;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int SEL_W      = 2;
    localparam int N_LEVELS   = 1 << SEL_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [SEL_W-1:0] {
        TBL_A = 2'd0,
        TBL_B = 2'd1,
        TBL_C = 2'd2,
        TBL_D = 2'd3
    } tbl_e;

    // Returns the receive trigger level for a table and an entry index.
    function automatic cnt_t level_of(input tbl_e tbl, input logic [SEL_W-1:0] idx);
        cnt_t v;
        unique case (tbl)
            TBL_A: unique case (idx)
                2'd0: v = cnt_t'(1);
                2'd1: v = cnt_t'(4);
                2'd2: v = cnt_t'(8);
                default: v = cnt_t'(14);
            endcase
            TBL_B: unique case (idx)
                2'd0: v = cnt_t'(8);
                2'd1: v = cnt_t'(16);
                2'd2: v = cnt_t'(24);
                default: v = cnt_t'(28);
            endcase
            TBL_C: unique case (idx)
                2'd0: v = cnt_t'(8);
                2'd1: v = cnt_t'(16);
                2'd2: v = cnt_t'(56);
                default: v = cnt_t'(60);
            endcase
            default: unique case (idx)
                2'd0: v = cnt_t'(16);
                2'd1: v = cnt_t'(64);
                2'd2: v = cnt_t'(128);
                default: v = cnt_t'(224);
            endcase
        endcase
        return v;
    endfunction
endpackage

// File: rtl/rx_fc_thresh.sv
// rx_fc_thresh: works out the trigger level and the stop/go thresholds.
// Tables A-C: stop at the next entry up (saturating at the top entry),
// go at the next entry down (0 below the bottom entry).
// Table D: stop at the level, go just below it. Assumes every table-D level is non-zero.
module rx_fc_thresh
    import rx_fc_pkg::*;
(
    input  logic [SEL_W-1:0] tbl_sel,
    input  logic [SEL_W-1:0] lvl_sel,
    output cnt_t             lvl,
    output cnt_t             hi_thr,
    output cnt_t             lo_thr
);
    localparam logic [SEL_W-1:0] TOP_IDX = SEL_W'(N_LEVELS - 1);

    tbl_e tbl;
    assign tbl = tbl_e'(tbl_sel);

    // Selected entry and its two neighbours in the same table.
    always_comb begin
        lvl = level_of(tbl, lvl_sel);
        if (tbl == TBL_D) begin
            hi_thr = lvl;
            lo_thr = lvl - cnt_t'(1);
        end else begin
            hi_thr = (lvl_sel == TOP_IDX) ? lvl : level_of(tbl, lvl_sel + SEL_W'(1));
            lo_thr = (lvl_sel == '0)      ? '0  : level_of(tbl, lvl_sel - SEL_W'(1));
        end
    end
endmodule

// File: rtl/rx_fc_rts.sv
// rx_fc_rts: registered set/reset latch for the active-low flow-control line.
// Assumes hi_thr > lo_thr. Stop takes priority over go.
module rx_fc_rts
    import rx_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic sw_rts,
    input  cnt_t count,
    input  cnt_t hi_thr,
    input  cnt_t lo_thr,
    output logic rts_n
);
    // Software mode follows the request bit; auto mode sets, clears or holds.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rts_n <= 1'b0;
        else if (!auto_en)           rts_n <= ~sw_rts;
        else if (count >= hi_thr)    rts_n <= 1'b1;
        else if (count <= lo_thr)    rts_n <= 1'b0;
    end

    a_r2_manual: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (rts_n == !$past(sw_rts)));
    a_r3_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && count >= hi_thr) |=> rts_n);
    a_r4_go: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && count <= lo_thr && count < hi_thr) |=> !rts_n);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && count > lo_thr && count < hi_thr) |=> $stable(rts_n));
endmodule

// File: rtl/rx_fc_trig.sv
// rx_fc_trig: registered receive trigger flag, set while count >= level.
module rx_fc_trig
    import rx_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t count,
    input  cnt_t lvl,
    output logic trig
);
    // Compare the count against the trigger level once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= (count >= lvl);
    end

    a_r9_trig_set: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= lvl) |=> trig);
    a_r9_trig_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (count < lvl) |=> !trig);
endmodule

// File: rtl/rx_flow_ctl.sv
// rx_flow_ctl: receive FIFO flow control. Drives rts_n from the FIFO count with
// table-based hysteresis and flags when the trigger level is reached.
// Assumes rx_count never exceeds the FIFO depth. Both outputs are registered.
module rx_flow_ctl
    import rx_fc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [SEL_W-1:0] tbl_sel,
    input  logic [SEL_W-1:0] lvl_sel,
    input  logic             auto_en,
    input  logic             sw_rts,
    output logic             rts_n,
    output logic             rx_trig
);
    cnt_t lvl, hi_thr, lo_thr;

    rx_fc_thresh u_thresh (
        .tbl_sel (tbl_sel),
        .lvl_sel (lvl_sel),
        .lvl     (lvl),
        .hi_thr  (hi_thr),
        .lo_thr  (lo_thr)
    );

    rx_fc_rts u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (auto_en),
        .sw_rts  (sw_rts),
        .count   (rx_count),
        .hi_thr  (hi_thr),
        .lo_thr  (lo_thr),
        .rts_n   (rts_n)
    );

    rx_fc_trig u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .count (rx_count),
        .lvl   (lvl),
        .trig  (rx_trig)
    );

    // R6 / R7: thresholds stay on the correct side of the trigger level.
    a_r6_hi_order: assert property (@(posedge clk) disable iff (!rst_n)
        hi_thr >= lvl);
    a_r7_lo_order: assert property (@(posedge clk) disable iff (!rst_n)
        lo_thr < lvl);
endmodule

// File: tb/tb_rx_flow_ctl.sv
module tb_rx_flow_ctl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] rx_count;
    logic [1:0] tbl_sel, lvl_sel;
    logic       auto_en, sw_rts;
    logic       rts_n, rx_trig;
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    rx_flow_ctl dut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tbl_sel(tbl_sel),
        .lvl_sel(lvl_sel), .auto_en(auto_en), .sw_rts(sw_rts),
        .rts_n(rts_n), .rx_trig(rx_trig)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (count=%0d tbl=%0d lvl=%0d)",
                     req, act, exp, rx_count, tbl_sel, lvl_sel);
        end
    endtask

    // Present a count, let one edge pass, check rts_n at the next falling edge.
    task automatic put(input int c, input logic exp_rts, input string req);
        rx_count = 9'(c);
        @(negedge clk);
        check(req, rts_n, exp_rts);
    endtask

    task automatic setup(input int t, input int l);
        auto_en = 1'b1;
        tbl_sel = 2'(t);
        lvl_sel = 2'(l);
        put(0, 1'b0, "R4");
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rx_count = 9'd100; auto_en = 1'b1; sw_rts = 1'b0;
        tbl_sel = 2'd2; lvl_sel = 2'd2;
        repeat (3) @(negedge clk);
        check("R1", rts_n, 1'b0);
        check("R1", rx_trig, 1'b0);
        rst_n = 1'b1; rx_count = 9'd0;
        @(negedge clk);
        check("R1", rts_n, 1'b0);
        check("R1", rx_trig, 1'b0);
    endtask

    task automatic t_manual();
        auto_en = 1'b0; tbl_sel = 2'd0; lvl_sel = 2'd0;
        sw_rts = 1'b1; put(256, 1'b0, "R2");
        sw_rts = 1'b0; put(0, 1'b1, "R2");
        sw_rts = 1'b0; put(100, 1'b1, "R2");
        sw_rts = 1'b1; put(3, 1'b0, "R2");
    endtask

    task automatic t_table_c_mid();
        setup(2, 2);                    // level 56, stop 60, go 16
        put(55, 1'b0, "R3"); check("R9", rx_trig, 1'b0);
        put(56, 1'b0, "R3"); check("R9", rx_trig, 1'b1);
        put(59, 1'b0, "R3");
        put(60, 1'b1, "R3");
        put(30, 1'b1, "R5");
        put(17, 1'b1, "R5");
        put(16, 1'b0, "R4");
        put(40, 1'b0, "R5");
    endtask

    task automatic t_table_a();
        setup(0, 1);                    // level 4, stop 8, go 1
        put(7, 1'b0, "R3");
        put(8, 1'b1, "R3");
        put(2, 1'b1, "R5");
        put(1, 1'b0, "R4");
    endtask

    task automatic t_top();
        setup(2, 3);                    // level 60, stop 60, go 56
        put(59, 1'b0, "R6");
        put(60, 1'b1, "R6");
        put(57, 1'b1, "R6");
        put(56, 1'b0, "R6");
    endtask

    task automatic t_bottom();
        setup(1, 0);                    // level 8, stop 16, go 0
        put(15, 1'b0, "R7");
        put(16, 1'b1, "R7");
        put(1, 1'b1, "R7");
        put(0, 1'b0, "R7");
    endtask

    task automatic t_table_d();
        setup(3, 1);                    // level 64
        put(63, 1'b0, "R8");
        put(64, 1'b1, "R8"); check("R10", rx_trig, 1'b1);
        put(63, 1'b0, "R8"); check("R10", rx_trig, 1'b0);
    endtask

    task automatic t_trig_manual();
        auto_en = 1'b0; sw_rts = 1'b1; tbl_sel = 2'd0; lvl_sel = 2'd3;  // level 14
        put(14, 1'b0, "R9"); check("R9", rx_trig, 1'b1);
        put(13, 1'b0, "R9"); check("R9", rx_trig, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_manual();
        t_table_c_mid();
        t_table_a();
        t_top();
        t_bottom();
        t_table_d();
        t_trig_manual();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule